// File: doc/BRIEF.md
# Vectored Interrupt Controller with Normal and Critical Outputs

This block gathers 32 interrupt request lines and presents them to a processor core as two lines: a normal interrupt and a critical interrupt. For each request line, software picks whether the line is active-high or active-low, whether it is level- or edge-sensitive, whether it is enabled, and which of the two outputs it drives. Every line passes through a two-flop synchroniser before it reaches the pending-status logic.

A small register port gives software its view of the block. The port has a 4-bit word offset, a read strobe, a write strobe, 32-bit write data and 32-bit read data. Software can clear pending bits, set pending bits, read the raw and the enabled pending state, and program the configuration.

An optional vector unit turns the highest-priority pending critical source into an address. That address is a programmable base plus 512 times the source's rank. One configuration bit picks which end of the source range has the top priority. The vector unit is kept or removed by a parameter.

Top module: `irqc_vec32`

## Requirements
- R1: The line-sense bit of a source chooses its active level. Value 0 means active-low, so the raw input is inverted. Value 1 means active-high. Each input reaches the pending logic through a two-flop synchroniser.
- R2: A source with trigger bit 0 is level-sensitive. Its pending bit copies the normalised input on every clock.
- R3: A source with trigger bit 1 is edge-sensitive. Its pending bit is set on a 0-to-1 change of the normalised input, and only a software clear removes it. If a set and a clear arrive in the same cycle, the set wins.
- R4: The normal output is high when some source is pending, enabled and routed normal. The critical output is high when some source is pending, enabled and routed critical (routing bit 1).
- R5: Writing offset 0 clears each pending bit written as 1. Writing offset 1 sets each pending bit written as 1. Reads of offset 0 and of offset 1 both return the pending word.
- R6: Offset 6 reads back pending AND enable. Writes to offset 6 and to offset 7 change no state.
- R7: A write to the vector-setup register (offset 8) always stores bit 1 as 0. In that register, bit 0 = 0 gives source 0 the top priority, and bit 0 = 1 gives source 31 the top priority.
- R8: Offset 7 reads the vector, which is formed only from sources that are pending, enabled and routed critical. With at least one such source, the vector is the setup value with bits 1:0 cleared, plus 512×i for the lowest such index i (forward order) or plus 512×(31−i) for the highest such index i (reverse order). With none, the vector is 0.
- R9: Offsets 9 to 15 read 0. Read data is 0 whenever the read strobe is low. With the vector unit removed by parameter, offsets 7 and 8 read 0.
- R10: Reset sets the enable, routing, line-sense, trigger, vector-setup and pending registers to 0. Every source then comes out of reset active-low and level-sensitive. Synchroniser stages reset to the inactive level, so an all-ones input held through reset leaves nothing pending.
- R11: Both outputs and the vector depend only on registered state. A register write shows on the outputs in the cycle after the write edge and not before.
- Register map (word offsets): 0 pending-clear, 1 pending-set, 2 enable, 3 routing, 4 line-sense, 5 trigger, 6 enabled-pending, 7 vector, 8 vector-setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Raw interrupt request lines |
| bus_off | input | 4 | Register word offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq_norm | output | 1 | Normal interrupt output |
| irq_crit | output | 1 | Critical interrupt output |

## Verification
Seeded random sequences mix input changes with writes to enable, routing, line-sense, trigger, vector-setup and the two pending ports. This separates level-following from sticky edge capture, and it shows whether a line-sense flip acts like a real input edge. Directed cases cover the following:
- one critical source against two, with both priority orders, which tells forward ranking apart from reverse ranking;
- bit 1 forced to zero in the vector-setup register;
- ignored writes to the read-only offsets;
- undefined offsets and a low read strobe;
- the exact cycle in which an enable write reaches the normal output.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int IRQC_W         = 32;
    localparam int IRQC_IW        = $clog2(IRQC_W);
    localparam int IRQC_OFF_W     = 4;
    localparam int IRQC_VEC_SHIFT = 9;

    typedef logic [IRQC_W-1:0] irqc_word_t;

    typedef enum logic [IRQC_OFF_W-1:0] {
        OFF_PEND_CLR = 4'd0,
        OFF_PEND_SET = 4'd1,
        OFF_ENA      = 4'd2,
        OFF_ROUTE    = 4'd3,
        OFF_SENSE    = 4'd4,
        OFF_TRIG     = 4'd5,
        OFF_MPEND    = 4'd6,
        OFF_VEC      = 4'd7,
        OFF_VSETUP   = 4'd8
    } irqc_off_e;

    typedef struct packed {
        irqc_word_t ena;
        irqc_word_t route;
        irqc_word_t sense;
        irqc_word_t trig;
        irqc_word_t vsetup;
    } irqc_cfg_t;

    // Rank of the winning source: distance from the top-priority end.
    function automatic logic [IRQC_IW-1:0] irqc_rank(input irqc_word_t p,
                                                     input logic       top_high);
        logic [IRQC_IW-1:0] r;
        r = '0;
        if (!top_high) begin
            for (int i = IRQC_W-1; i >= 0; i--)
                if (p[i]) r = IRQC_IW'(i);
        end else begin
            for (int i = 0; i < IRQC_W; i++)
                if (p[i]) r = IRQC_IW'(IRQC_W-1-i);
        end
        return r;
    endfunction

    function automatic irqc_word_t irqc_vsetup_fix(input irqc_word_t w);
        return w & ~irqc_word_t'(2);
    endfunction

endpackage

// File: rtl/irqc_front.sv
module irqc_front
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  irqc_word_t raw,
    input  irqc_word_t sense,
    output irqc_word_t norm,
    output irqc_word_t rise
);
    irqc_word_t prev_q;

    for (genvar g = 0; g < IRQC_W; g++) begin : g_line
        logic s1_q, s2_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= 1'b1;
                s2_q <= 1'b1;
            end else begin
                s1_q <= raw[g];
                s2_q <= s1_q;
            end
        end
        assign norm[g] = sense[g] ? s2_q : ~s2_q;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= norm;
    end

    assign rise = norm & ~prev_q;

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter bit VEC_EN = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [IRQC_OFF_W-1:0] off,
    input  irqc_word_t            wdata,
    input  irqc_word_t            norm,
    input  irqc_word_t            rise,
    output irqc_cfg_t             cfg,
    output irqc_word_t            pend
);
    irqc_off_e  off_e;
    irqc_word_t set_mask, clr_mask, hw_set, hw_clr, pend_d;

    assign off_e    = irqc_off_e'(off);
    assign set_mask = (wr && off_e == OFF_PEND_SET) ? wdata : '0;
    assign clr_mask = (wr && off_e == OFF_PEND_CLR) ? wdata : '0;
    assign hw_set   = (~cfg.trig & norm) | (cfg.trig & rise);
    assign hw_clr   = ~cfg.trig & ~norm;
    assign pend_d   = hw_set | set_mask | (pend & ~clr_mask & ~hw_clr);

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            case (off_e)
                OFF_ENA:    cfg.ena    <= wdata;
                OFF_ROUTE:  cfg.route  <= wdata;
                OFF_SENSE:  cfg.sense  <= wdata;
                OFF_TRIG:   cfg.trig   <= wdata;
                OFF_VSETUP: cfg.vsetup <= VEC_EN ? irqc_vsetup_fix(wdata) : '0;
                default:    ;
            endcase
        end
    end

    // R2: a level source mirrors the normalised input of the previous cycle
    a_r2_level_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~$past(cfg.trig) & ($past(norm) ^ pend) & ~$past(set_mask)) == '0));

    // R3: an edge source stays pending until software clears it
    a_r3_edge_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend) & $past(cfg.trig) & ~$past(clr_mask) & ~pend) == '0));

    // R5: the set port forces the written bits
    a_r5_set_port: assert property (@(posedge clk) disable iff (rst)
        (wr && off_e == OFF_PEND_SET) |=> ((pend & $past(wdata)) == $past(wdata)));

    // R10: state right after reset is cleared
    a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg == '0 && pend == '0));

endmodule

// File: rtl/irqc_vec.sv
module irqc_vec
    import irqc_pkg::*;
#(
    parameter bit VEC_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  irqc_word_t crit_pend,
    input  irqc_word_t vsetup,
    output irqc_word_t vec
);
    if (VEC_EN) begin : g_vec
        logic [IRQC_IW-1:0] rank;
        irqc_word_t         base;

        assign rank = irqc_rank(crit_pend, vsetup[0]);
        assign base = vsetup & ~irqc_word_t'(3);
        assign vec  = (crit_pend != '0)
                    ? base + (irqc_word_t'(rank) << IRQC_VEC_SHIFT)
                    : '0;

        // R8: the rank step never disturbs the base bits below the step size
        a_r8_vec_low_bits: assert property (@(posedge clk) disable iff (rst)
            (crit_pend != '0) |->
                (vec[IRQC_VEC_SHIFT-1:0] == base[IRQC_VEC_SHIFT-1:0]));
    end else begin : g_novec
        assign vec = '0;
    end

endmodule

// File: rtl/irqc_vec32.sv
module irqc_vec32
    import irqc_pkg::*;
#(
    parameter bit VEC_EN = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IRQC_W-1:0]     irq_in,
    input  logic [IRQC_OFF_W-1:0] bus_off,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [IRQC_W-1:0]     bus_wdata,
    output logic [IRQC_W-1:0]     bus_rdata,
    output logic                  irq_norm,
    output logic                  irq_crit
);
    irqc_word_t norm, rise, pend, vec, live, crit_pend, rd_val;
    irqc_cfg_t  cfg;

    irqc_front u_front (
        .clk   (clk),
        .rst   (rst),
        .raw   (irq_in),
        .sense (cfg.sense),
        .norm  (norm),
        .rise  (rise)
    );

    irqc_regs #(.VEC_EN(VEC_EN)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .off   (bus_off),
        .wdata (bus_wdata),
        .norm  (norm),
        .rise  (rise),
        .cfg   (cfg),
        .pend  (pend)
    );

    assign live      = pend & cfg.ena;
    assign crit_pend = live & cfg.route;

    irqc_vec #(.VEC_EN(VEC_EN)) u_vec (
        .clk       (clk),
        .rst       (rst),
        .crit_pend (crit_pend),
        .vsetup    (cfg.vsetup),
        .vec       (vec)
    );

    assign irq_norm = |(live & ~cfg.route);
    assign irq_crit = |crit_pend;

    always_comb begin
        case (irqc_off_e'(bus_off))
            OFF_PEND_CLR,
            OFF_PEND_SET: rd_val = pend;
            OFF_ENA:      rd_val = cfg.ena;
            OFF_ROUTE:    rd_val = cfg.route;
            OFF_SENSE:    rd_val = cfg.sense;
            OFF_TRIG:     rd_val = cfg.trig;
            OFF_MPEND:    rd_val = live;
            OFF_VEC:      rd_val = VEC_EN ? vec : '0;
            OFF_VSETUP:   rd_val = VEC_EN ? cfg.vsetup : '0;
            default:      rd_val = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? rd_val : '0;

    // R6: enabled-pending read never shows a bit that is not pending
    a_r6_mpend_subset: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && irqc_off_e'(bus_off) == OFF_MPEND) |-> ((bus_rdata & ~pend) == '0));

    // R4: the critical line implies the vector unit sees a pending source
    a_r4_crit_has_source: assert property (@(posedge clk) disable iff (rst)
        irq_crit |-> (($countones(pend & cfg.ena & cfg.route)) != 0));

endmodule

// File: tb/irqc_vec32_bench.sv
module irqc_vec32_bench;
    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] O_CLR = 4'd0, O_SET = 4'd1, O_ENA = 4'd2, O_ROUTE = 4'd3,
                           O_SENSE = 4'd4, O_TRIG = 4'd5, O_MPEND = 4'd6,
                           O_VEC = 4'd7, O_VSET = 4'd8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '1;
    logic [3:0]  bus_off = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_norm, irq_crit;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_in = '1, m_ena = '0, m_route = '0, m_sense = '0, m_trig = '0;
    logic [31:0] m_vset = '0, m_pend = '0, m_norm = '0;

    irqc_vec32 u_irqc_vec32 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_off(bus_off),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_norm(irq_norm), .irq_crit(irq_crit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_vec(input logic [31:0] cp, input logic [31:0] vs);
        logic [31:0] v;
        v = 32'd0;
        if (cp != 0) begin
            v = vs & 32'hFFFF_FFFC;
            if (!vs[0]) begin
                for (int i = 0; i < 32; i++)
                    if (cp[i]) begin v = v + 32'(i) * 32'd512; break; end
            end else begin
                for (int i = 31; i >= 0; i--)
                    if (cp[i]) begin v = v + 32'(31 - i) * 32'd512; break; end
            end
        end
        return v;
    endfunction

    // Model: level bits copy the normalised input, edge bits stick on a rise
    task automatic model_apply();
        logic [31:0] nn;
        nn = m_in ^ ~m_sense;
        m_pend = (m_pend & m_trig) | (m_trig & nn & ~m_norm) | (~m_trig & nn);
        m_norm = nn;
    endtask

    task automatic bus_write(input logic [3:0] o, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_off = o; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] o, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_off = o;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic op_wr(input logic [3:0] o, input logic [31:0] d);
        bus_write(o, d);
        case (o)
            O_CLR:   m_pend = m_pend & ~d;
            O_SET:   m_pend = m_pend | d;
            O_ENA:   m_ena = d;
            O_ROUTE: m_route = d;
            O_SENSE: m_sense = d;
            O_TRIG:  m_trig = d;
            O_VSET:  m_vset = d & 32'hFFFF_FFFD;
            default: ;
        endcase
        model_apply();
    endtask

    task automatic set_in(input logic [31:0] v);
        @(negedge clk);
        irq_in = v; m_in = v;
        model_apply();
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d, live;
        repeat (5) @(negedge clk);
        live = m_pend & m_ena;
        bus_read(O_CLR, d);   chk({tag, " R2 R3 pending"}, d, m_pend);
        bus_read(O_SET, d);   chk({tag, " R5 set-port read"}, d, m_pend);
        bus_read(O_MPEND, d); chk({tag, " R6 enabled-pending"}, d, live);
        bus_read(O_VEC, d);   chk({tag, " R8 vector"}, d, exp_vec(live & m_route, m_vset));
        chk({tag, " R4 normal out"}, 32'(irq_norm), 32'(|(live & ~m_route)));
        chk({tag, " R4 critical out"}, 32'(irq_crit), 32'(|(live & m_route)));
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R10: everything reads zero after reset
        for (int o = 0; o <= 8; o++) begin
            bus_read(4'(o), d);
            chk("R10 reset register", d, 32'd0);
        end
        chk("R10 reset outputs", {30'd0, irq_norm, irq_crit}, 32'd0);

        // R1: line sense
        op_wr(O_ENA, 32'h0000_0008);
        set_in(32'hFFFF_FFF7); check_all("R1 active-low asserted");
        op_wr(O_SENSE, 32'h0000_0008); check_all("R1 active-high idle");
        set_in(32'hFFFF_FFFF); check_all("R1 active-high asserted");

        // R2 / R3: level vs edge, software clear
        op_wr(O_TRIG, 32'h0000_0010);
        op_wr(O_ENA, 32'h0000_0018);
        set_in(32'hFFFF_FFE7); check_all("R2 level low, R3 edge capture");
        set_in(32'hFFFF_FFFF); check_all("R3 edge holds after input drop");
        op_wr(O_CLR, 32'h0000_0018); check_all("R3 clear edge, R2 level stays");

        // R7 / R8: vector and priority order
        op_wr(O_SENSE, 32'h0); op_wr(O_TRIG, 32'hFFFF_FFFF);
        op_wr(O_CLR, 32'hFFFF_FFFF); op_wr(O_ENA, 32'h0);
        op_wr(O_VSET, 32'hFFFF_FFFF);
        bus_read(O_VSET, d); chk("R7 bit1 forced zero", d, 32'hFFFF_FFFD);
        op_wr(O_VSET, 32'h0000_1000);
        op_wr(O_SET, 32'h0010_0020);
        op_wr(O_ROUTE, 32'h0010_0020);
        op_wr(O_ENA, 32'h0010_0020);
        check_all("R8 forward two sources");
        bus_read(O_VEC, d); chk("R8 forward value", d, 32'h0000_1A00);
        op_wr(O_VSET, 32'h0000_1001);
        bus_read(O_VEC, d); chk("R7 R8 reverse value", d, 32'h0000_2600);
        op_wr(O_CLR, 32'h0010_0000);
        bus_read(O_VEC, d); chk("R8 reverse single", d, 32'h0000_4400);

        // R6: writes to read-only offsets are ignored
        bus_write(O_VEC, 32'hFFFF_FFFF);
        bus_write(O_MPEND, 32'h0);
        check_all("R6 read-only writes");
        bus_read(O_VSET, d); chk("R6 setup untouched", d, 32'h0000_1001);

        // R9: undefined offsets and idle strobe
        for (int o = 9; o < 16; o++) begin
            bus_read(4'(o), d);
            chk("R9 undefined offset", d, 32'd0);
        end
        @(negedge clk); bus_off = O_ENA; #1 chk("R9 strobe low", bus_rdata, 32'd0);

        // R11: enable write reaches the normal output one edge later
        op_wr(O_ENA, 32'h0); op_wr(O_ROUTE, 32'h0);
        op_wr(O_SET, 32'h0000_0001);
        @(negedge clk);
        bus_wr = 1'b1; bus_off = O_ENA; bus_wdata = 32'h1;
        #1 chk("R11 not before write edge", 32'(irq_norm), 32'd0);
        @(negedge clk);
        bus_wr = 1'b0; m_ena = 32'h1;
        chk("R11 after write edge", 32'(irq_norm), 32'd1);

        // Random mix
        for (int it = 0; it < 160; it++) begin
            int sel;
            sel = $urandom_range(0, 8);
            case (sel)
                0: set_in($urandom());
                1: op_wr(O_ENA, $urandom());
                2: op_wr(O_ROUTE, $urandom());
                3: op_wr(O_SENSE, $urandom());
                4: op_wr(O_TRIG, $urandom());
                5: op_wr(O_VSET, $urandom());
                6: op_wr(O_CLR, $urandom());
                7: op_wr(O_SET, $urandom() & $urandom());
                default: set_in(m_in ^ (32'd1 << $urandom_range(0, 31)));
            endcase
            check_all("random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule